// File: doc/BRIEF.md
# Nonvolatile Store Sequence Controller

This block sits in front of an 8192-byte volatile array that has a shadow nonvolatile copy. Through a synchronous port, the host issues single-cycle reads and writes. A read is an access with chip enable and output enable active and write enable inactive. A write is an access with chip enable and write enable active. Read data comes back one cycle later on a registered output with a valid flag.

The controller also watches every read-type access for a fixed unlock pattern of six addresses. When the sixth address arrives in order, the controller copies the volatile contents into the shadow array. The copy has two sweeps: an erase sweep over the shadow array, then a program sweep. When the power-good input rises, the controller copies the shadow array back into the volatile array. During either copy the busy output is high and all host accesses are dropped.

Both arrays are stored as rows of several bytes. Each sweep moves one whole row per clock.

Top module: `nv_store_ctrl`

## Requirements
- R1: After reset, busy_o and rd_valid_o are low. The unlock pointer waits for its first address. The shadow array holds all zeros.
- R2: A read (ce_i=1, we_i=0, oe_i=1) accepted while idle with power good sets rd_valid_o on the next cycle, with rd_data_o equal to the addressed byte. In every other cycle rd_valid_o is 0.
- R3: A write (ce_i=1, we_i=1) accepted while idle with power good stores wdata_i at addr_i. oe_i has no effect on a write.
- R4: Six consecutive read-type accesses at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0F start a store. busy_o rises in the cycle after the sixth access.
- R5: The first five accesses of the unlock pattern return array data like any read. The sixth access returns no data (rd_valid_o stays 0).
- R6: A write, or a read-type access at an address other than the next expected one, abandons a partial pattern, and no store follows. An abandoning access at 0x0000 counts as the first step of a new pattern.
- R7: oe_i is not needed for an access to count toward the pattern. An access with ce_i=1, we_i=0 and oe_i=0 advances the pattern but returns no data.
- R8: A store keeps busy_o high for 2×(8192/LANES) cycles (2048 by default). It leaves the shadow array equal to the volatile array as it was when the store started.
- R9: While busy_o is high, reads return nothing and writes leave the volatile array unchanged.
- R10: A rising edge on pg_i starts a recall. busy_o stays high for 8192/LANES cycles (1024 by default), after which the volatile array equals the shadow array. The access in the rising-edge cycle is dropped.
- R11: While pg_i is low, accesses are dropped and the unlock pattern returns to its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable, active high |
| we_i | input | 1 | Write enable, active high |
| oe_i | input | 1 | Output enable, active high |
| addr_i | input | 13 | Byte address |
| wdata_i | input | 8 | Write data |
| pg_i | input | 1 | Power good; a rising edge starts a recall |
| rd_data_o | output | 8 | Read data, valid one cycle after a read |
| rd_valid_o | output | 1 | rd_data_o carries read data |
| busy_o | output | 1 | Store or recall in progress |

## Verification
The hardest state to reach from the ports is a pattern that is abandoned and restarted in the same access. This is a read at 0x0000 in the middle of a partial pattern. The bench first sends part of the pattern, then 0x0000, then the complete remainder. A store follows only if the restart counted as step one.

The effect of a store cannot be seen directly. To make it visible, the bench changes the volatile array after a store, drops pg_i, raises it again, and reads the recalled bytes back. It also issues writes during a store, and the recall then shows that those writes were ignored.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  parameter int ADDR_W  = 13;
  parameter int DATA_W  = 8;
  parameter int RUN_LEN = 6;
  localparam int STEP_W = $clog2(RUN_LEN);

  typedef enum logic [1:0] {
    SW_IDLE   = 2'd0,
    SW_ERASE  = 2'd1,
    SW_PROG   = 2'd2,
    SW_RECALL = 2'd3
  } sweep_e;

  function automatic logic [ADDR_W-1:0] unlock_addr(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    return 13'h0000;
      3'd1:    return 13'h1555;
      3'd2:    return 13'h0AAA;
      3'd3:    return 13'h1FFF;
      3'd4:    return 13'h10F0;
      default: return 13'h0F0F;
    endcase
  endfunction
endpackage

// File: rtl/nvs_unlock.sv
module nvs_unlock
  import nvs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [STEP_W-1:0] step_o,
  output logic              fire_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(RUN_LEN - 1);

  logic [STEP_W-1:0] step_q;
  logic match, at_last, restart;

  assign match   = (addr_i == unlock_addr(step_q));
  assign at_last = (step_q == LAST);
  assign restart = (addr_i == unlock_addr('0));
  assign fire_o  = rd_i & match & at_last;
  assign step_o  = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            step_q <= '0;
    else if (clear_i || wr_i) step_q <= '0;
    else if (rd_i) begin
      if (match)            step_q <= at_last ? '0 : step_q + 1'b1;
      else                  step_q <= restart ? STEP_W'(1) : '0;  // broken run may restart
    end
  end
endmodule

// File: rtl/nvs_sweep.sv
module nvs_sweep
  import nvs_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             store_go_i,
  input  logic             recall_go_i,
  output sweep_e           state_o,
  output logic [ROW_W-1:0] row_o,
  output logic             busy_o
);
  sweep_e           state_q;
  logic [ROW_W-1:0] row_q;
  logic             row_last;

  assign row_last = &row_q;
  assign state_o  = state_q;
  assign row_o    = row_q;
  assign busy_o   = (state_q != SW_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SW_IDLE;
      row_q   <= '0;
    end else begin
      case (state_q)
        SW_IDLE: begin
          row_q <= '0;
          if (store_go_i)       state_q <= SW_ERASE;
          else if (recall_go_i) state_q <= SW_RECALL;
        end
        SW_ERASE: begin
          row_q <= row_q + 1'b1;
          if (row_last) state_q <= SW_PROG;
        end
        SW_PROG: begin
          row_q <= row_q + 1'b1;
          if (row_last) state_q <= SW_IDLE;
        end
        default: begin
          row_q <= row_q + 1'b1;
          if (row_last) state_q <= SW_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays
  import nvs_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  sweep_e            sweep_i,
  input  logic [ADDR_W-$clog2(LANES)-1:0] row_i
);
  localparam int LANE_W = $clog2(LANES);
  localparam int ROW_W  = ADDR_W - LANE_W;
  localparam int ROWS   = 2 ** ROW_W;
  localparam int WORD_W = LANES * DATA_W;

  logic [WORD_W-1:0] vol_q [ROWS];
  logic [WORD_W-1:0] nv_q  [ROWS];

  logic [ROW_W-1:0]  h_row;
  logic [LANE_W-1:0] h_lane;
  logic [WORD_W-1:0] h_word;

  assign h_row  = host_addr_i[ADDR_W-1:LANE_W];
  assign h_lane = host_addr_i[LANE_W-1:0];
  assign h_word = vol_q[h_row];
  assign host_rdata_o = h_word[h_lane*DATA_W +: DATA_W];

  // volatile array: no reset, filled by recall
  always_ff @(posedge clk_i) begin
    if (sweep_i == SW_RECALL)
      vol_q[row_i] <= nv_q[row_i];
    else if (host_we_i)
      vol_q[h_row][h_lane*DATA_W +: DATA_W] <= host_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROWS; i++) nv_q[i] <= '0;
    end else if (sweep_i == SW_ERASE) begin
      nv_q[row_i] <= '1;
    end else if (sweep_i == SW_PROG) begin
      nv_q[row_i] <= vol_q[row_i];
    end
  end
endmodule

// File: rtl/nv_store_ctrl.sv
module nv_store_ctrl
  import nvs_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pg_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o
);
  localparam int ROW_W = ADDR_W - $clog2(LANES);

  logic              pg_q, pg_rise, open;
  logic              rd_evt, wr_evt, store_fire;
  logic [STEP_W-1:0] step;
  sweep_e            sweep;
  logic [ROW_W-1:0]  row;
  logic [DATA_W-1:0] arr_rdata;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  assign pg_rise = pg_i & ~pg_q;
  assign open    = ~busy_o & pg_i & ~pg_rise;
  assign rd_evt  = open & ce_i & ~we_i;
  assign wr_evt  = open & ce_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pg_q <= 1'b1;  // powered at reset; recall needs a real rise
    else         pg_q <= pg_i;
  end

  nvs_unlock u_unlock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (~pg_i),
    .rd_i    (rd_evt),
    .wr_i    (wr_evt),
    .addr_i  (addr_i),
    .step_o  (step),
    .fire_o  (store_fire)
  );

  nvs_sweep #(.ROW_W(ROW_W)) u_sweep (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .store_go_i  (store_fire),
    .recall_go_i (pg_rise),
    .state_o     (sweep),
    .row_o       (row),
    .busy_o      (busy_o)
  );

  nvs_arrays #(.LANES(LANES)) u_arrays (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (wr_evt),
    .host_addr_i  (addr_i),
    .host_wdata_i (wdata_i),
    .host_rdata_o (arr_rdata),
    .sweep_i      (sweep),
    .row_i        (row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_evt & oe_i & ~store_fire;
      rd_data_q  <= (rd_evt & oe_i & ~store_fire) ? arr_rdata : '0;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker
  import nvs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_i,
  input logic              we_i,
  input logic              oe_i,
  input logic              pg_i,
  input logic              busy_o,
  input logic              rd_valid_o,
  input logic              fire_i,
  input logic              pg_q_i,
  input logic [STEP_W-1:0] step_i
);
  p_valid_after_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(ce_i && oe_i && !we_i && !busy_o && pg_i));

  p_quiet_when_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !rd_valid_o);

  p_write_aborts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && we_i && !busy_o && pg_i && pg_q_i) |=> (step_i == '0));

  p_fire_starts_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> busy_o);

  p_busy_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(fire_i || (pg_i && !pg_q_i)));

  p_lowpower_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_i |=> (step_i == '0));
endmodule

bind nv_store_ctrl nvs_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_i       (ce_i),
  .we_i       (we_i),
  .oe_i       (oe_i),
  .pg_i       (pg_i),
  .busy_o     (busy_o),
  .rd_valid_o (rd_valid_o),
  .fire_i     (store_fire),
  .pg_q_i     (pg_q),
  .step_i     (step)
);

// File: tb/sim_nv_store_ctrl.sv
module sim_nv_store_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 1024;

  logic clk = 0, rst_n = 0;
  logic ce = 0, we = 0, oe = 0, pg = 0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid, busy;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_store_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .we_i(we), .oe_i(oe),
    .addr_i(addr), .wdata_i(wdata), .pg_i(pg),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .busy_o(busy)
  );

  // behavioural reference
  int unsigned magic[$] = '{32'h0000, 32'h1555, 32'h0AAA, 32'h1FFF, 32'h10F0, 32'h0F0F};
  logic [7:0] mvol[int];
  logic [7:0] msh[int];
  int  m_step = 0, m_cnt = 0;
  bit  m_pgprev = 1, m_valid = 0;
  logic [7:0] m_data = 0;

  function automatic logic [7:0] vrd(int a);
    return mvol.exists(a) ? mvol[a] : 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_cnt = 0; m_pgprev = 1; m_valid = 0; m_data = 0;
      msh.delete();
    end else begin
      m_valid = 0;
      if (m_cnt > 0) m_cnt--;
      else if (pg && !m_pgprev) begin
        m_cnt = ROWS; mvol = msh; m_step = 0;
      end else if (!pg) m_step = 0;
      else if (ce) begin
        if (we) begin
          mvol[int'(addr)] = wdata; m_step = 0;
        end else if (int'(addr) == int'(magic[m_step])) begin
          if (m_step == 5) begin
            m_cnt = 2*ROWS; msh = mvol; m_step = 0;
          end else begin
            m_step++; m_valid = oe; m_data = vrd(int'(addr));
          end
        end else begin
          m_step = (addr == 13'h0000) ? 1 : 0;
          m_valid = oe; m_data = vrd(int'(addr));
        end
      end
      m_pgprev = pg;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, busy, m_cnt > 0, "busy_o");
      check(cur_req, rd_valid, m_valid, "rd_valid_o");
      if (m_valid) check(cur_req, rd_data, m_data, "rd_data_o");
    end
  end

  task automatic acc(bit c, bit w, bit o, int a, int d);
    ce = c; we = w; oe = o; addr = 13'(a); wdata = 8'(d);
    @(negedge clk);
    ce = 0; we = 0; oe = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_busy(output int len);
    len = 0;
    while (busy && len < 5000) begin @(negedge clk); len++; end
  endtask

  task automatic run_seq(bit o);
    foreach (magic[i]) acc(1, 0, o, int'(magic[i]), 0);
  endtask

  task automatic finish_up();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    int len;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", busy, 0, "busy after reset");
    check("R1", rd_valid, 0, "rd_valid after reset");

    // power-up recall of all-zero shadow
    cur_req = "R10";
    pg = 1; @(negedge clk);
    wait_busy(len);
    check("R10", len, ROWS, "recall busy length");
    for (int i = 0; i < 8; i++) acc(1, 0, 1, i * 997, 0);

    cur_req = "R3";
    for (int i = 0; i < 24; i++) acc(1, 1, i % 2, (i * 389 + 7) & 13'h1FFF, i * 37 + 3);
    foreach (magic[i]) acc(1, 1, 0, int'(magic[i]), 8'hA0 + i);
    cur_req = "R2";
    for (int i = 0; i < 24; i++) acc(1, 0, 1, (i * 389 + 7) & 13'h1FFF, 0);
    cur_req = "R7";
    acc(1, 0, 0, 13'h0123, 0);
    idle(1);

    cur_req = "R6";  // abort by write
    acc(1, 0, 1, 0, 0); acc(1, 0, 1, 13'h1555, 0); acc(1, 0, 1, 13'h0AAA, 0);
    acc(1, 1, 0, 13'h0200, 8'h77);
    acc(1, 0, 1, 13'h1FFF, 0); acc(1, 0, 1, 13'h10F0, 0); acc(1, 0, 1, 13'h0F0F, 0);
    idle(2);
    check("R6", busy, 0, "no store after write abort");
    // abort by wrong address
    acc(1, 0, 1, 0, 0); acc(1, 0, 1, 13'h1555, 0); acc(1, 0, 1, 13'h0ABA, 0);
    acc(1, 0, 1, 13'h0AAA, 0); acc(1, 0, 1, 13'h1FFF, 0);
    acc(1, 0, 1, 13'h10F0, 0); acc(1, 0, 1, 13'h0F0F, 0);
    idle(2);
    check("R6", busy, 0, "no store after wrong address");

    // restart through 0x0000 then complete: R5 data on steps 1-5
    cur_req = "R5";
    acc(1, 0, 1, 0, 0); acc(1, 0, 1, 13'h1555, 0);
    acc(1, 0, 1, 0, 0);
    acc(1, 0, 1, 13'h1555, 0); acc(1, 0, 1, 13'h0AAA, 0); acc(1, 0, 1, 13'h1FFF, 0);
    acc(1, 0, 1, 13'h10F0, 0); acc(1, 0, 1, 13'h0F0F, 0);
    check("R4", busy, 1, "store started after sixth address");
    cur_req = "R9";
    for (int i = 0; i < 6; i++) acc(1, 1, 0, (i * 389 + 7) & 13'h1FFF, 8'hEE);
    for (int i = 0; i < 6; i++) acc(1, 0, 1, (i * 389 + 7) & 13'h1FFF, 0);
    wait_busy(len);
    check("R8", len + 12, 2 * ROWS, "store busy length");
    for (int i = 0; i < 6; i++) acc(1, 0, 1, (i * 389 + 7) & 13'h1FFF, 0);

    // change volatile data, cycle power, recall stored copy
    cur_req = "R3";
    for (int i = 0; i < 24; i++) acc(1, 1, 0, (i * 389 + 7) & 13'h1FFF, 8'h11);
    cur_req = "R11";
    pg = 0; idle(1);
    acc(1, 1, 0, 13'h0300, 8'h99);
    acc(1, 0, 1, 13'h0300, 0);
    acc(1, 0, 1, 0, 0); acc(1, 0, 1, 13'h1555, 0);
    idle(1);
    cur_req = "R10";
    pg = 1; @(negedge clk);
    wait_busy(len);
    check("R10", len, ROWS, "second recall length");
    cur_req = "R8";
    for (int i = 0; i < 24; i++) acc(1, 0, 1, (i * 389 + 7) & 13'h1FFF, 0);
    acc(1, 0, 1, 13'h0300, 0);

    // full run without output enable
    cur_req = "R7";
    run_seq(0);
    check("R7", busy, 1, "store with oe low");
    wait_busy(len);
    check("R8", len, 2 * ROWS, "store busy length oe low");
    idle(2);
    finish_up();
  end
endmodule